// File: doc/BRIEF.md
# Stored-Image Configuration Loader

This block loads configuration images from a local ROM into one or more reconfigurable targets, so a host processor only has to ask for an image and never streams the bits itself. The host gives an image number, a routing choice and an optional sub-range, then pulses a start strobe. A small sequencer reads a directory entry for that image, fetches the image words through a synchronous ROM read port, and shifts them out serially, most significant bit first. A gated configuration clock and an enable go out with the data.

Two routings are offered. In chained mode every target shares the configuration clock and enable, and the data enters only the head of the chain (target 0). The targets pass the stream along among themselves. In select mode the data, clock and enable all go to the one target chosen by the select input, and every other target sees all three held low. A partial load sends only a word range of the image, and it takes proportionally fewer configuration clock cycles.

Top module: `cfgld_top`

## Requirements
- R1: While reset is high and on the first cycle after it, busy, done and every target enable, clock and data output are low.
- R2: The ROM holds the directory at word addresses 0..7. Image i has its start address at address 2i and its length in words at address 2i+1. The default contents give image i a start of 16+16i and a length of i+2. Every other address a holds (37a+11) mod 256. A start strobe sampled while idle is accepted, and busy is high from the next cycle on. The configuration enable is never high unless busy is high.
- R3: The configuration clock is high only while the enable is high. It is low in the first enabled cycle and then alternates every system cycle, so each bit spans one low cycle and one high cycle.
- R4: The bits leave MSB first, word after word, with no gaps. The first bit appears 6 cycles after the accepting edge, and a load of N words keeps the enable high for exactly 16N consecutive cycles.
- R5: In chained mode (chain_mode=1 at the strobe) every target gets the enable and clock, and only target 0 gets data.
- R6: In select mode (chain_mode=0) only the target numbered by tgt_sel gets enable, clock and data. At most one target data line is ever high.
- R7: With part_en=1 the load starts part_off words into the image and sends min(part_len, length-part_off) words.
- R8: A partial load with part_off at or beyond the image length, or with part_len=0, sends no bits. Its done pulse comes 4 cycles after the accepting edge.
- R9: Start strobes and changes of any request input while busy is high have no effect on the load in progress.
- R10: Done is high for one cycle, right after the last bit's high clock cycle. In that cycle the enable and busy are low. A strobe present in the done cycle starts a new load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Load request strobe |
| img_idx | input | 2 | Image number in the directory |
| chain_mode | input | 1 | 1 = chained routing, 0 = select routing |
| tgt_sel | input | 2 | Target chosen in select mode |
| part_en | input | 1 | Send only a word range |
| part_off | input | 8 | First word of the range, relative to the image start |
| part_len | input | 8 | Number of words in the range |
| busy | output | 1 | Load in progress |
| done | output | 1 | One-cycle end-of-load pulse |
| tgt_en | output | 4 | Per-target configuration enable |
| tgt_clk | output | 4 | Per-target gated configuration clock |
| tgt_dat | output | 4 | Per-target serial configuration data |

## Verification
Busy rises one cycle after the accepting edge. The first enabled bit follows 6 cycles after that edge. Done follows 6+16N cycles after it for an N-word load, or 4 cycles after it when the range is empty. The bench advances a behavioural model at each rising edge: a queue of expected bits built from the ROM formula, a cycle counter since acceptance, and the latched routing. It compares all five outputs against that model at every falling edge, so each result is checked in exactly the cycle it is due and never at the edge where it changes.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;

    localparam int WORD_W     = 8;
    localparam int ADDR_W     = 8;
    localparam int NUM_IMG    = 4;
    localparam int N_TGT      = 4;
    localparam int IMG_BASE   = 16;
    localparam int IMG_STRIDE = 16;
    localparam int IDX_W      = $clog2(NUM_IMG);
    localparam int SEL_W      = $clog2(N_TGT);
    localparam int BIT_W      = $clog2(WORD_W);
    localparam int DIR_WORDS  = 2 * NUM_IMG;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [ADDR_W-1:0] addr_t;

    typedef enum logic [2:0] {
        ST_IDLE, ST_DIRS, ST_DIRL, ST_CALC, ST_FETCH, ST_LOAD, ST_SHIFT, ST_DONE
    } state_e;

    typedef struct packed {
        logic             chain;
        logic [SEL_W-1:0] sel;
        logic             part;
        word_t            off;
        word_t            plen;
        logic [IDX_W-1:0] idx;
    } req_t;

    typedef struct packed {
        logic en;
        logic clk;
        logic dat;
    } lane_t;

    typedef struct packed {
        addr_t first;
        word_t count;
    } range_t;

    // ROM contents: directory pairs (start, length) then a computed fill pattern
    function automatic word_t rom_word(addr_t a);
        int ai;
        ai = int'(a);
        if (ai < DIR_WORDS) begin
            if (ai % 2 == 0) return word_t'(IMG_BASE + IMG_STRIDE * (ai / 2));
            return word_t'(ai / 2 + 2);
        end
        return word_t'(ai * 37 + 11);
    endfunction

    // Word range actually sent, after the partial-load clamp
    function automatic range_t calc_range(word_t start, word_t len, logic part,
                                          word_t off, word_t plen);
        range_t r;
        word_t  rem;
        r.first = addr_t'(start);
        r.count = len;
        if (part) begin
            if (off >= len) begin
                r.count = '0;
            end else begin
                rem     = len - off;
                r.count = (plen < rem) ? plen : rem;
                r.first = addr_t'(start) + addr_t'(off);
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/cfgld_rom.sv
module cfgld_rom
    import cfgld_pkg::*;
(
    input  logic  clk,
    input  addr_t addr,
    output word_t data
);

    always_ff @(posedge clk) begin
        data <= rom_word(addr);
    end

endmodule

// File: rtl/cfgld_seq.sv
module cfgld_seq
    import cfgld_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    input  req_t  req_in,
    output addr_t rom_addr,
    input  word_t rom_data,
    output req_t  req_q,
    output lane_t lane,
    output logic  busy,
    output logic  done
);

    state_e           state;
    word_t            start_q;
    addr_t            ptr;
    word_t            words_left;
    word_t            sh;
    logic [BIT_W-1:0] bitcnt;
    logic             phase;
    range_t           rng;

    assign rng = calc_range(start_q, rom_data, req_q.part, req_q.off, req_q.plen);

    always_comb begin
        case (state)
            ST_DIRS: rom_addr = addr_t'({req_q.idx, 1'b0});
            ST_DIRL: rom_addr = addr_t'({req_q.idx, 1'b1});
            default: rom_addr = ptr;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            req_q      <= '0;
            start_q    <= '0;
            ptr        <= '0;
            words_left <= '0;
            sh         <= '0;
            bitcnt     <= '0;
            phase      <= 1'b0;
        end else begin
            case (state)
                ST_IDLE, ST_DONE: begin
                    if (start) begin
                        req_q <= req_in;
                        state <= ST_DIRS;
                    end else begin
                        state <= ST_IDLE;
                    end
                end
                ST_DIRS: state <= ST_DIRL;
                ST_DIRL: begin
                    start_q <= rom_data;
                    state   <= ST_CALC;
                end
                ST_CALC: begin
                    ptr        <= rng.first;
                    words_left <= rng.count;
                    state      <= (rng.count == '0) ? ST_DONE : ST_FETCH;
                end
                ST_FETCH: begin
                    ptr   <= ptr + 1'b1;
                    state <= ST_LOAD;
                end
                ST_LOAD: begin
                    sh     <= rom_data;
                    bitcnt <= '0;
                    phase  <= 1'b0;
                    state  <= ST_SHIFT;
                end
                ST_SHIFT: begin
                    phase <= ~phase;
                    if (phase) begin
                        if (bitcnt == BIT_W'(WORD_W - 1)) begin
                            if (words_left == word_t'(1)) begin
                                state <= ST_DONE;
                            end else begin
                                sh         <= rom_data;
                                ptr        <= ptr + 1'b1;
                                words_left <= words_left - 1'b1;
                                bitcnt     <= '0;
                            end
                        end else begin
                            sh     <= {sh[WORD_W-2:0], 1'b0};
                            bitcnt <= bitcnt + 1'b1;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy     = (state != ST_IDLE) && (state != ST_DONE);
    assign done     = (state == ST_DONE);
    assign lane.en  = (state == ST_SHIFT);
    assign lane.clk = lane.en & phase;
    assign lane.dat = lane.en & sh[WORD_W-1];

endmodule

// File: rtl/cfgld_route.sv
module cfgld_route
    import cfgld_pkg::*;
#(
    parameter int NT = N_TGT,
    localparam int SW = (NT > 1) ? $clog2(NT) : 1
)(
    input  lane_t          lane,
    input  logic           chain,
    input  logic [SW-1:0]  sel,
    output logic [NT-1:0]  tgt_en,
    output logic [NT-1:0]  tgt_clk,
    output logic [NT-1:0]  tgt_dat
);

    for (genvar i = 0; i < NT; i++) begin : g_tgt
        logic hit;
        assign hit        = chain | (sel == SW'(i));
        assign tgt_en[i]  = hit & lane.en;
        assign tgt_clk[i] = hit & lane.clk;
        if (i == 0) begin : g_head
            assign tgt_dat[i] = hit & lane.dat;
        end else begin : g_rest
            assign tgt_dat[i] = ~chain & hit & lane.dat;
        end
    end

endmodule

// File: rtl/cfgld_top.sv
module cfgld_top
    import cfgld_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [IDX_W-1:0] img_idx,
    input  logic             chain_mode,
    input  logic [SEL_W-1:0] tgt_sel,
    input  logic             part_en,
    input  logic [WORD_W-1:0] part_off,
    input  logic [WORD_W-1:0] part_len,
    output logic             busy,
    output logic             done,
    output logic [N_TGT-1:0] tgt_en,
    output logic [N_TGT-1:0] tgt_clk,
    output logic [N_TGT-1:0] tgt_dat
);

    req_t  req_in;
    req_t  req_q;
    addr_t rom_addr;
    word_t rom_data;
    lane_t lane;

    always_comb begin
        req_in.chain = chain_mode;
        req_in.sel   = tgt_sel;
        req_in.part  = part_en;
        req_in.off   = part_off;
        req_in.plen  = part_len;
        req_in.idx   = img_idx;
    end

    cfgld_rom i_rom (
        .clk  (clk),
        .addr (rom_addr),
        .data (rom_data)
    );

    cfgld_seq i_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .req_in   (req_in),
        .rom_addr (rom_addr),
        .rom_data (rom_data),
        .req_q    (req_q),
        .lane     (lane),
        .busy     (busy),
        .done     (done)
    );

    cfgld_route #(.NT(N_TGT)) i_route (
        .lane    (lane),
        .chain   (req_q.chain),
        .sel     (req_q.sel),
        .tgt_en  (tgt_en),
        .tgt_clk (tgt_clk),
        .tgt_dat (tgt_dat)
    );

endmodule

// File: rtl/cfgld_chk.sv
module cfgld_chk
    import cfgld_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic [N_TGT-1:0] tgt_en,
    input logic [N_TGT-1:0] tgt_clk,
    input logic [N_TGT-1:0] tgt_dat
);

    p_clk_gated_r3: assert property (@(posedge clk) disable iff (rst)
        (tgt_clk & ~tgt_en) == '0);

    p_clk_toggle_r4: assert property (@(posedge clk) disable iff (rst)
        ((|tgt_en) && $past(|tgt_en)) |-> ((|tgt_clk) != $past(|tgt_clk)));

    p_single_dat_r6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(tgt_dat) && ((tgt_dat & ~tgt_en) == '0));

    p_busy_cause_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start));

    p_en_in_busy_r2: assert property (@(posedge clk) disable iff (rst)
        (|tgt_en) |-> busy);

    p_done_clean_r10: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && tgt_en == '0));

    p_done_after_bits_r10: assert property (@(posedge clk) disable iff (rst)
        $fell(|tgt_en) |-> done);

    p_done_short_r10: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done || $past(start)));

endmodule

bind cfgld_top cfgld_chk i_chk (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .tgt_en  (tgt_en),
    .tgt_clk (tgt_clk),
    .tgt_dat (tgt_dat)
);

// File: tb/test_cfgld_top.sv
module test_cfgld_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [1:0] img_idx = '0;
    logic       chain_mode = 1'b0;
    logic [1:0] tgt_sel = '0;
    logic       part_en = 1'b0;
    logic [7:0] part_off = '0;
    logic [7:0] part_len = '0;
    logic       busy, done;
    logic [3:0] tgt_en, tgt_clk, tgt_dat;

    always #4 clk = ~clk;

    cfgld_top i_cfgld_top (
        .clk(clk), .rst(rst), .start(start), .img_idx(img_idx),
        .chain_mode(chain_mode), .tgt_sel(tgt_sel), .part_en(part_en),
        .part_off(part_off), .part_len(part_len), .busy(busy), .done(done),
        .tgt_en(tgt_en), .tgt_clk(tgt_clk), .tgt_dat(tgt_dat)
    );

    int    errors = 0;
    int    checks = 0;
    int    cyc = 0;
    string tag = "R1";

    // reference model state
    bit    m_act = 0;
    int    m_t = 0;
    int    m_end = 0;
    int    m_cnt = 0;
    bit    m_chain = 0;
    int    m_sel = 0;
    bit    m_q[$];

    function automatic int ref_word(int a);
        if (a < 8) return (a % 2 == 0) ? 16 + 16 * (a / 2) : a / 2 + 2;
        return (a * 37 + 11) % 256;
    endfunction

    task automatic accept();
        int st, len, first, cnt, w;
        st    = ref_word(2 * int'(img_idx));
        len   = ref_word(2 * int'(img_idx) + 1);
        first = st;
        cnt   = len;
        if (part_en) begin
            if (int'(part_off) >= len) cnt = 0;
            else begin
                cnt   = (int'(part_len) < len - int'(part_off)) ? int'(part_len) : len - int'(part_off);
                first = st + int'(part_off);
            end
        end
        m_q.delete();
        for (int k = 0; k < cnt; k++) begin
            w = ref_word(first + k);
            for (int b = 7; b >= 0; b--) m_q.push_back(w[b]);
        end
        m_cnt   = cnt;
        m_end   = (cnt == 0) ? 4 : 6 + 16 * cnt;
        m_chain = chain_mode;
        m_sel   = int'(tgt_sel);
        m_act   = 1;
        m_t     = 1;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            m_act = 0;
            m_t   = 0;
        end else if ((!m_act || m_t == m_end) && start) begin
            accept();
        end else if (m_act) begin
            if (m_t == m_end) m_act = 0;
            else m_t++;
        end
    end

    task automatic chk(string what, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h at cycle %0d", tag, what, got, exp, cyc);
        end
    endtask

    always @(negedge clk) begin
        logic       e_busy, e_done, e_en, e_clk, e_dat;
        logic [3:0] v_en, v_clk, v_dat;
        int         j;
        e_busy = m_act && (m_t < m_end);
        e_done = m_act && (m_t == m_end);
        e_en   = m_act && (m_cnt > 0) && (m_t >= 6) && (m_t < m_end);
        j      = m_t - 6;
        e_clk  = e_en && (j % 2 == 1);
        e_dat  = e_en && m_q[j / 2];
        for (int i = 0; i < 4; i++) begin
            v_en[i]  = e_en  && (m_chain || m_sel == i);
            v_clk[i] = e_clk && (m_chain || m_sel == i);
            v_dat[i] = e_dat && (m_chain ? (i == 0) : (m_sel == i));
        end
        chk("R2 busy", 32'(busy), 32'(e_busy));
        chk("R10 done", 32'(done), 32'(e_done));
        chk(m_chain ? "R5 enable" : "R6 enable", 32'(tgt_en), 32'(v_en));
        chk("R3 clock", 32'(tgt_clk), 32'(v_clk));
        chk("R4 data", 32'(tgt_dat), 32'(v_dat));
    end

    function automatic void summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endfunction

    always @(posedge clk) begin
        if (cyc > 100000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run hung, got %0d cycles expected under 100000", cyc);
            summary();
            $finish;
        end
    end

    task automatic idle_wait();
        @(negedge clk);
        while (m_act) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic run(string t, int idx, bit ch, int sel, bit pe, int off, int pl);
        @(negedge clk);
        #1;
        tag        = t;
        img_idx    = 2'(idx);
        chain_mode = ch;
        tgt_sel    = 2'(sel);
        part_en    = pe;
        part_off   = 8'(off);
        part_len   = 8'(pl);
        start      = 1'b1;
        @(negedge clk);
        #1 start = 1'b0;
        idle_wait();
    endtask

    initial begin
        // R1: reset state observed by the per-cycle compare
        tag = "R1";
        repeat (4) @(negedge clk);
        #1 rst = 1'b0;
        repeat (2) @(negedge clk);

        run("R5", 0, 1, 0, 0, 0, 0);    // chained, full image 0
        run("R6", 3, 0, 2, 0, 0, 0);    // select target 2, full image 3
        run("R4", 1, 0, 3, 0, 0, 0);    // select target 3, word order
        run("R7", 3, 0, 1, 1, 1, 2);    // partial middle range
        run("R7", 2, 1, 0, 1, 2, 9);    // partial clamped to the image end
        run("R8", 1, 0, 0, 1, 3, 1);    // offset at the image length
        run("R8", 2, 1, 0, 1, 0, 0);    // zero-length range

        // R9: strobes and request changes during a load are ignored
        @(negedge clk);
        #1 tag = "R9";
        img_idx = 2'd2; chain_mode = 1'b0; tgt_sel = 2'd1; part_en = 1'b0;
        start = 1'b1;
        @(negedge clk);
        #1 start = 1'b0;
        repeat (10) @(negedge clk);
        #1 img_idx = 2'd0; tgt_sel = 2'd3; chain_mode = 1'b1; start = 1'b1;
        @(negedge clk);
        #1 start = 1'b0;
        repeat (20) @(negedge clk);
        #1 start = 1'b1; part_en = 1'b1;
        @(negedge clk);
        #1 start = 1'b0; part_en = 1'b0;
        idle_wait();

        // R10: strobe held through the done cycle restarts at once
        @(negedge clk);
        #1 tag = "R10";
        img_idx = 2'd0; chain_mode = 1'b0; tgt_sel = 2'd0; start = 1'b1;
        repeat (40) @(negedge clk);
        #1 start = 1'b0;
        idle_wait();

        summary();
        $finish;
    end

endmodule